// File: doc/BRIEF.md
# Block Floating-Point Pass Scaler

This block sits beside a radix butterfly datapath and decides how far every sample is scaled down on each pass of a transform. It also keeps a block floating-point exponent tag. At the start of a pass it is told the pass index, and it publishes a right-shift amount. The shift is two on the opening pass. On later passes it depends on a scaling mode latched at transform start: the guarded mode uses three and the lean mode uses two. Samples pass through a one-deep valid/ready stage that applies the current shift arithmetically, with truncation toward minus infinity.

At the end of each pass the datapath reports how many bits of headroom (0 to 3) its results actually consumed. Shifts applied but not consumed are added to the tag. That makes the tag the number of compensating left shifts a consumer should apply. The tag saturates at 15 in guarded mode. In lean mode it saturates at 14, and 15 is reserved as an overflow marker. The marker is set when growth exceeds the applied shift and holds until the next transform start. After the last pass the tag is presented with a one-cycle valid strobe.

Stream rules: the input is accepted on any cycle with `s_valid` and `s_ready` high. `s_ready` is high whenever the output register is empty or is being drained in that cycle. While `m_valid` is high and `m_ready` is low, the output word and its valid are held and no input is taken.

Top module: `bfp_pass_scaler`

## Requirements
- R1: After reset, shift_amt is 2, tag is 0, tag_valid is 0 and m_valid is 0.
- R2: A pass_start with pass_idx equal to 0 sets shift_amt to 2 on the following cycle, in either mode.
- R3: In guarded mode (lean_mode latched as 0), a pass_start with a nonzero pass_idx sets shift_amt to 3 on the following cycle.
- R4: In lean mode (lean_mode latched as 1), every pass_start sets shift_amt to 2.
- R5: At each pass_end, the tag grows by shift_amt minus growth when growth is below shift_amt, and by 0 otherwise.
- R6: In guarded mode the tag saturates at 15.
- R7: In lean mode the tag saturates at 14. A pass_end whose growth exceeds shift_amt forces the tag to 15, and the tag stays at 15 until the next xform_start.
- R8: A pass_end with last_pass high drives tag_valid high for exactly the next cycle. On that cycle tag shows the final value, and tag keeps that value afterwards.
- R9: xform_start clears the tag accumulator and the overflow marker and latches lean_mode. Changes on lean_mode at any other time have no effect.
- R10: An accepted sample appears on m_data as s_data arithmetically shifted right by shift_amt, truncated toward minus infinity, with m_valid high on the next cycle.
- R11: While m_valid is high and m_ready is low, m_data is held, m_valid stays high and s_ready is low.
- R12: A sample accepted in the same cycle as a pass_start is shifted by the amount in force before that pass_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xform_start | input | 1 | Transform start pulse |
| lean_mode | input | 1 | Scaling mode, latched at xform_start (1 = two shifts every pass) |
| pass_start | input | 1 | Pass start pulse |
| pass_idx | input | PASS_W | Index of the pass being started |
| pass_end | input | 1 | Pass end pulse, qualifies growth and last_pass |
| last_pass | input | 1 | Marks the final pass of the transform |
| growth | input | 2 | Headroom bits the pass results consumed |
| shift_amt | output | 2 | Right shift in force for the current pass |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample ready |
| s_data | input | DATA_W | Input sample, two's complement |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Output sample ready |
| m_data | output | DATA_W | Scaled output sample |
| tag | output | 4 | Compensating left-shift count, or 15 for overflow in lean mode |
| tag_valid | output | 1 | One-cycle strobe for a fresh tag |

## Verification
A sample can be accepted by the shifting stage in the same cycle that a pass_start reloads the shift amount. The bench sets the shift to 2 and then raises pass_start (for a guarded-mode later pass) and s_valid together with s_data = 64. The output must read 16, not 8. On the next cycle shift_amt must read 3, which shows that the old amount governed the colliding sample and the new one took effect afterwards.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  localparam int SHIFT_W = 2;
  localparam int TAG_W   = 4;
  localparam int GROW_W  = 2;

  localparam logic [SHIFT_W-1:0] SHIFT_BASE  = 2'd2;
  localparam logic [SHIFT_W-1:0] SHIFT_GUARD = 2'd3;

  localparam logic [TAG_W-1:0] TAG_OVF       = 4'd15;
  localparam logic [TAG_W-1:0] TAG_MAX_GUARD = 4'd15;
  localparam logic [TAG_W-1:0] TAG_MAX_LEAN  = 4'd14;

  typedef enum logic {
    MODE_GUARD = 1'b0,
    MODE_LEAN  = 1'b1
  } scale_mode_e;
endpackage

// File: rtl/bfp_shift_sched.sv
module bfp_shift_sched
  import bfp_pkg::*;
#(
  parameter int PASS_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xform_start,
  input  logic                lean_mode,
  input  logic                pass_start,
  input  logic [PASS_W-1:0]   pass_idx,
  output scale_mode_e         mode_q,
  output logic [SHIFT_W-1:0]  shift_amt
);
  scale_mode_e mode_eff;

  always_comb begin
    mode_eff = xform_start ? scale_mode_e'(lean_mode) : mode_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MODE_GUARD;
      shift_amt <= SHIFT_BASE;
    end else begin
      if (xform_start) mode_q <= scale_mode_e'(lean_mode);
      if (pass_start) begin
        if (pass_idx == '0 || mode_eff == MODE_LEAN) shift_amt <= SHIFT_BASE;
        else                                         shift_amt <= SHIFT_GUARD;
      end
    end
  end

  // R2
  first_pass_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_start && pass_idx == '0 |=> shift_amt == SHIFT_BASE);

  // R4
  lean_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_start && mode_eff == MODE_LEAN |=> shift_amt == SHIFT_BASE);
endmodule

// File: rtl/bfp_tag_accum.sv
module bfp_tag_accum
  import bfp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xform_start,
  input  scale_mode_e        mode_q,
  input  logic [SHIFT_W-1:0] shift_amt,
  input  logic               pass_end,
  input  logic               last_pass,
  input  logic [GROW_W-1:0]  growth,
  output logic [TAG_W-1:0]   tag,
  output logic               tag_valid
);
  logic [TAG_W-1:0]   acc_q, acc_d;
  logic               ovf_q, ovf_d;
  logic [SHIFT_W-1:0] spare;
  logic [TAG_W:0]     sum;
  logic [TAG_W-1:0]   limit;

  always_comb begin
    spare = (growth >= shift_amt) ? '0 : SHIFT_W'(shift_amt - growth);
    sum   = {1'b0, acc_q} + {{(TAG_W+1-SHIFT_W){1'b0}}, spare};
    limit = (mode_q == MODE_LEAN) ? TAG_MAX_LEAN : TAG_MAX_GUARD;
    acc_d = acc_q;
    ovf_d = ovf_q;
    if (xform_start) begin
      acc_d = '0;
      ovf_d = 1'b0;
    end else if (pass_end) begin
      if (ovf_q || (mode_q == MODE_LEAN && growth > shift_amt)) begin
        ovf_d = 1'b1;
        acc_d = TAG_OVF;
      end else if (sum > {1'b0, limit}) begin
        acc_d = limit;
      end else begin
        acc_d = sum[TAG_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      ovf_q     <= 1'b0;
      tag       <= '0;
      tag_valid <= 1'b0;
    end else begin
      acc_q     <= acc_d;
      ovf_q     <= ovf_d;
      tag_valid <= pass_end && last_pass && !xform_start;
      if (pass_end && last_pass && !xform_start) tag <= acc_d;
    end
  end

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !xform_start |=> acc_q == TAG_OVF);

  // R7
  lean_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_q && mode_q == MODE_LEAN |-> acc_q <= TAG_MAX_LEAN);
endmodule

// File: rtl/bfp_sample_shifter.sv
module bfp_sample_shifter
  import bfp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SHIFT_W-1:0] shift_amt,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [DATA_W-1:0]  s_data,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [DATA_W-1:0]  m_data
);
  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_valid && s_ready) begin
      m_valid <= 1'b1;
      m_data  <= $signed(s_data) >>> shift_amt;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  // R11
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data));
endmodule

// File: rtl/bfp_pass_scaler.sv
module bfp_pass_scaler
  import bfp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PASS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xform_start,
  input  logic              lean_mode,
  input  logic              pass_start,
  input  logic [PASS_W-1:0] pass_idx,
  input  logic              pass_end,
  input  logic              last_pass,
  input  logic [1:0]        growth,
  output logic [1:0]        shift_amt,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic [3:0]        tag,
  output logic              tag_valid
);
  scale_mode_e mode_q;

  bfp_shift_sched #(.PASS_W(PASS_W)) sched_i (
    .clk(clk), .rst_n(rst_n), .xform_start(xform_start), .lean_mode(lean_mode),
    .pass_start(pass_start), .pass_idx(pass_idx), .mode_q(mode_q), .shift_amt(shift_amt)
  );

  bfp_tag_accum accum_i (
    .clk(clk), .rst_n(rst_n), .xform_start(xform_start), .mode_q(mode_q),
    .shift_amt(shift_amt), .pass_end(pass_end), .last_pass(last_pass), .growth(growth),
    .tag(tag), .tag_valid(tag_valid)
  );

  bfp_sample_shifter #(.DATA_W(DATA_W)) shifter_i (
    .clk(clk), .rst_n(rst_n), .shift_amt(shift_amt), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  // R8
  tag_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_valid |-> $past(pass_end) && $past(last_pass));
endmodule

// File: tb/bfp_pass_scaler_tb_top.sv
module bfp_pass_scaler_tb_top;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 16;
  localparam int PASS_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xform_start = 1'b0, lean_mode = 1'b0, pass_start = 1'b0, pass_end = 1'b0, last_pass = 1'b0;
  logic [PASS_W-1:0] pass_idx = '0;
  logic [1:0] growth = '0;
  logic [1:0] shift_amt;
  logic s_valid = 1'b0, s_ready, m_valid, m_ready = 1'b1, tag_valid;
  logic [DATA_W-1:0] s_data = '0, m_data;
  logic [3:0] tag;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bfp_pass_scaler #(.DATA_W(DATA_W), .PASS_W(PASS_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .xform_start(xform_start), .lean_mode(lean_mode),
    .pass_start(pass_start), .pass_idx(pass_idx), .pass_end(pass_end), .last_pass(last_pass),
    .growth(growth), .shift_amt(shift_amt), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .tag(tag), .tag_valid(tag_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic start_xform(input logic lean);
    xform_start = 1'b1; lean_mode = lean;
    step();
    xform_start = 1'b0;
  endtask

  task automatic run_pass(input int idx, input logic [1:0] g, input logic last);
    pass_start = 1'b1; pass_idx = PASS_W'(idx);
    step();
    pass_start = 1'b0;
    pass_end = 1'b1; growth = g; last_pass = last;
    step();
    pass_end = 1'b0; last_pass = 1'b0; growth = '0;
  endtask

  task automatic t_reset();
    check("R1 shift", 32'(shift_amt), 2);
    check("R1 tag", 32'(tag), 0);
    check("R1 tag_valid", 32'(tag_valid), 0);
    check("R1 m_valid", 32'(m_valid), 0);
  endtask

  task automatic t_schedule();
    start_xform(1'b0);
    pass_start = 1'b1; pass_idx = 4'd1; step(); pass_start = 1'b0;
    check("R3 guarded later pass", 32'(shift_amt), 3);
    pass_start = 1'b1; pass_idx = 4'd0; step(); pass_start = 1'b0;
    check("R2 guarded first pass", 32'(shift_amt), 2);
    lean_mode = 1'b1; step();
    pass_start = 1'b1; pass_idx = 4'd2; step(); pass_start = 1'b0;
    check("R9 mode change ignored", 32'(shift_amt), 3);
    start_xform(1'b1);
    pass_start = 1'b1; pass_idx = 4'd0; step(); pass_start = 1'b0;
    check("R2 lean first pass", 32'(shift_amt), 2);
    pass_start = 1'b1; pass_idx = 4'd3; step(); pass_start = 1'b0;
    check("R4 lean later pass", 32'(shift_amt), 2);
  endtask

  task automatic t_accumulate();
    start_xform(1'b0);
    run_pass(0, 2'd1, 1'b0);
    run_pass(1, 2'd2, 1'b0);
    run_pass(2, 2'd3, 1'b0);
    run_pass(3, 2'd0, 1'b1);
    check("R8 tag_valid", 32'(tag_valid), 1);
    check("R5 tag sum", 32'(tag), 5);
    step();
    check("R8 strobe one cycle", 32'(tag_valid), 0);
    check("R8 tag held", 32'(tag), 5);
  endtask

  task automatic t_sat_guard();
    start_xform(1'b0);
    for (int i = 0; i < 5; i++) run_pass(i, 2'd0, 1'b0);
    run_pass(5, 2'd0, 1'b1);
    check("R6 guarded saturation", 32'(tag), 15);
  endtask

  task automatic t_sat_lean();
    start_xform(1'b1);
    for (int i = 0; i < 7; i++) run_pass(i, 2'd0, 1'b0);
    run_pass(7, 2'd0, 1'b1);
    check("R7 lean saturation", 32'(tag), 14);
  endtask

  task automatic t_overflow();
    start_xform(1'b1);
    run_pass(0, 2'd3, 1'b0);
    run_pass(1, 2'd0, 1'b1);
    check("R7 overflow sticky", 32'(tag), 15);
    start_xform(1'b1);
    run_pass(0, 2'd0, 1'b1);
    check("R9 overflow cleared", 32'(tag), 2);
  endtask

  task automatic t_shift();
    start_xform(1'b0);
    pass_start = 1'b1; pass_idx = 4'd1; step(); pass_start = 1'b0;
    s_valid = 1'b1; s_data = 16'hFF9C; step(); s_valid = 1'b0;
    check("R10 m_valid", 32'(m_valid), 1);
    check("R10 negative floor", 32'(m_data), 32'h0000FFF3);
    step();
    check("R10 drained", 32'(m_valid), 0);
  endtask

  task automatic t_backpressure();
    m_ready = 1'b0;
    s_valid = 1'b1; s_data = 16'd80; step();
    s_data = 16'd800; step();
    check("R11 s_ready low", 32'(s_ready), 0);
    check("R11 data held", 32'(m_data), 10);
    step();
    check("R11 valid held", 32'(m_valid), 1);
    s_valid = 1'b0; m_ready = 1'b1; step();
    check("R11 released", 32'(m_valid), 0);
  endtask

  task automatic t_collide();
    start_xform(1'b0);
    pass_start = 1'b1; pass_idx = 4'd0; step();
    pass_idx = 4'd1; s_valid = 1'b1; s_data = 16'd64; step();
    pass_start = 1'b0; s_valid = 1'b0;
    check("R12 old shift used", 32'(m_data), 16);
    check("R12 new shift after", 32'(shift_amt), 3);
    step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_schedule();
    t_accumulate();
    t_sat_guard();
    t_sat_lean();
    t_overflow();
    t_shift();
    t_backpressure();
    t_collide();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule